// File: doc/BRIEF.md
# Sticky Interrupt Status Capture

This block sits beside the serial engine of a quad-SPI flash controller. It turns short event strobes from the engine into sticky flags that software reads as one 32-bit status word. Each flag follows its own clearing rule:
- some clear when the word is read;
- some clear at the start or end of a command;
- the time-out flag clears only on a control write that carries the time-out reset command;
- the transfer-complete flags clear when the matching DMA counter is rewritten.

Two flags are live levels taken from the DMA counter values. These values arrive as inputs; the counters themselves are not part of this block. The interrupt line of the attached memory device passes through a two-flop synchronizer. A two-state machine then turns it into rise and fall pulses. The states are `LINE_LOW` and `LINE_HIGH`, and they have two transitions:
- `LINE_LOW` to `LINE_HIGH` when the synchronized line reads 1. This emits a rise pulse.
- `LINE_HIGH` to `LINE_LOW` when the synchronized line reads 0. This emits a fall pulse.

A registered interrupt request is the OR of the status bits that the mask input enables. All flag updates take effect at the clock edge that samples the strobe. The status word shows the new value right after that edge. A read strobe returns the value held before the edge and clears the read-clearable flags at that edge.

Top module: `qsts_status_capture`

## Requirements
- R1: After reset the status word is 0x000000F0 and `irq` is 0.
- R2: Bit 17 sets on `ev_timeout`. Only `tout_clr` clears it; a status read leaves it set.
- R3: Bit 13 sets on a rising edge of `mem_irq_raw` and bit 12 on a falling edge. The change appears after the third clock edge that follows the input change (two synchronizer flops, then the flag). Both bits clear on a status read.
- R4: Bit 15 sets on `ev_cs_rise`. It clears on `ev_cmd_start` or on a status read.
- R5: Bit 14 sets on `ev_cs_fall`. It clears on `ev_cmd_end` or on a status read.
- R6: Bit 8 sets on `ev_cs_rise`, bit 10 on `ev_instr_end`, bit 11 on `ev_last_wr` and bit 3 on `ev_overrun`. All four clear on a status read.
- R7: Bit 11 does not set while `wr_access_count` is 0.
- R8: Bit 7 is 1 exactly when `tx_cnt` and `tx_next_cnt` were both zero at the previous edge. Bit 6 follows the same rule for `rx_cnt` and `rx_next_cnt`.
- R9: Bit 5 sets in the cycle after `tx_cnt` goes from nonzero to zero, and clears on `tx_cnt_wr`. Bit 4 does the same for `rx_cnt` and `rx_cnt_wr`. A counter that simply stays at zero does not set the bit again.
- R10: When a set event and a clearing condition hit the same bit at the same edge, the bit ends up set.
- R11: Bits 31:18, 16, 9 and 2:0 always read 0.
- R12: `irq` equals the OR of (status AND `irq_mask`) as it stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_cs_rise | input | 1 | Chip select deasserted (rise) strobe |
| ev_cs_fall | input | 1 | Chip select asserted (fall) strobe |
| ev_cmd_start | input | 1 | Command start strobe |
| ev_cmd_end | input | 1 | Command end strobe |
| ev_last_wr | input | 1 | Last write access sent strobe |
| ev_instr_end | input | 1 | Instruction end strobe |
| ev_timeout | input | 1 | Time-out strobe |
| ev_overrun | input | 1 | Receive overrun strobe |
| wr_access_count | input | CNT_W | Configured number of write accesses |
| tout_clr | input | 1 | Control write carrying the time-out reset command |
| tx_cnt | input | CNT_W | Transmit DMA counter value |
| tx_next_cnt | input | CNT_W | Transmit DMA next-counter value |
| rx_cnt | input | CNT_W | Receive DMA counter value |
| rx_next_cnt | input | CNT_W | Receive DMA next-counter value |
| tx_cnt_wr | input | 1 | Write to the transmit counter or next-counter |
| rx_cnt_wr | input | 1 | Write to the receive counter or next-counter |
| mem_irq_raw | input | 1 | Asynchronous interrupt line of the memory device |
| status_rd | input | 1 | Status word read strobe |
| irq_mask | input | 32 | Interrupt enable per status bit |
| status | output | 32 | Status word |
| irq | output | 1 | Registered interrupt request |

## Verification
A flag whose register holds a wrong value shows on `status` right after the next edge. A lost set, a clear that fires too early, or a read that wrongly clears the time-out flag can therefore be seen one cycle after the stimulus. A wrong state in the line edge machine makes bit 13 or 12 show up late, early, twice or never, measured against the three-edge latency. A wrong interrupt register shows on `irq` one cycle after the masked status changes.

// File: rtl/qsts_pkg.sv
package qsts_pkg;
    localparam int STAT_W    = 32;
    localparam int NUM_FLAGS = 12;

    // flag indices inside the flag vector
    localparam int F_TOUT      = 0;
    localparam int F_CSUP_CMD  = 1;
    localparam int F_CSDN_CMD  = 2;
    localparam int F_IRQ_UP    = 3;
    localparam int F_IRQ_DN    = 4;
    localparam int F_LAST_WR   = 5;
    localparam int F_INSTR_END = 6;
    localparam int F_CS_UP     = 7;
    localparam int F_TX_IDLE   = 8;
    localparam int F_RX_IDLE   = 9;
    localparam int F_TX_DONE   = 10;
    localparam int F_RX_DONE   = 11;

    // bit position of each flag in the status word (software decodes these)
    localparam int FLAG_POS [NUM_FLAGS] = '{17, 15, 14, 13, 12, 11, 10, 8, 7, 6, 5, 4};

    localparam int B_OVERRUN = 3;

    localparam logic [STAT_W-1:0] RESET_VALUE = 32'h0000_00F0;

    typedef enum logic {LINE_LOW, LINE_HIGH} line_state_e;
endpackage

// File: rtl/qsts_flag.sv
module qsts_flag #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= RESET_VAL;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/qsts_edge_watch.sv
module qsts_edge_watch
    import qsts_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic rise_o,
    output logic fall_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    line_state_e            state_q, state_d;
    logic                   line_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
    end

    assign line_s = sync_q[SYNC_STAGES-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_LOW;
        else        state_q <= state_d;
    end

    // next state and edge outputs
    always_comb begin
        state_d = state_q;
        rise_o  = 1'b0;
        fall_o  = 1'b0;
        unique case (state_q)
            LINE_LOW: if (line_s) begin
                state_d = LINE_HIGH;
                rise_o  = 1'b1;
            end
            LINE_HIGH: if (!line_s) begin
                state_d = LINE_LOW;
                fall_o  = 1'b1;
            end
        endcase
    end

    // R3: a rise pulse leaves the machine in LINE_HIGH
    assert_rise_enters_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> (state_q == LINE_HIGH));
endmodule

// File: rtl/qsts_status_capture.sv
module qsts_status_capture
    import qsts_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_cs_rise,
    input  logic              ev_cs_fall,
    input  logic              ev_cmd_start,
    input  logic              ev_cmd_end,
    input  logic              ev_last_wr,
    input  logic              ev_instr_end,
    input  logic              ev_timeout,
    input  logic              ev_overrun,
    input  logic [CNT_W-1:0]  wr_access_count,
    input  logic              tout_clr,
    input  logic [CNT_W-1:0]  tx_cnt,
    input  logic [CNT_W-1:0]  tx_next_cnt,
    input  logic [CNT_W-1:0]  rx_cnt,
    input  logic [CNT_W-1:0]  rx_next_cnt,
    input  logic              tx_cnt_wr,
    input  logic              rx_cnt_wr,
    input  logic              mem_irq_raw,
    input  logic              status_rd,
    input  logic [STAT_W-1:0] irq_mask,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    logic [NUM_FLAGS-1:0] set_v, clr_v, flag_q;
    logic                 line_rise, line_fall;
    logic                 tx_prev_zero_q, rx_prev_zero_q;
    logic                 tx_all_zero, rx_all_zero;
    logic                 ovr_q, irq_q;

    qsts_edge_watch #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (mem_irq_raw),
        .rise_o  (line_rise),
        .fall_o  (line_fall)
    );

    assign tx_all_zero = (tx_cnt == '0) && (tx_next_cnt == '0);
    assign rx_all_zero = (rx_cnt == '0) && (rx_next_cnt == '0);

    // previous-cycle zero state of the main counters, for reach-zero detect
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_prev_zero_q <= 1'b1;
            rx_prev_zero_q <= 1'b1;
        end else begin
            tx_prev_zero_q <= (tx_cnt == '0);
            rx_prev_zero_q <= (rx_cnt == '0);
        end
    end

    always_comb begin
        set_v = '0;
        clr_v = '0;
        set_v[F_TOUT]      = ev_timeout;
        clr_v[F_TOUT]      = tout_clr;
        set_v[F_CSUP_CMD]  = ev_cs_rise;
        clr_v[F_CSUP_CMD]  = ev_cmd_start || status_rd;
        set_v[F_CSDN_CMD]  = ev_cs_fall;
        clr_v[F_CSDN_CMD]  = ev_cmd_end || status_rd;
        set_v[F_IRQ_UP]    = line_rise;
        clr_v[F_IRQ_UP]    = status_rd;
        set_v[F_IRQ_DN]    = line_fall;
        clr_v[F_IRQ_DN]    = status_rd;
        set_v[F_LAST_WR]   = ev_last_wr && (wr_access_count != '0);
        clr_v[F_LAST_WR]   = status_rd;
        set_v[F_INSTR_END] = ev_instr_end;
        clr_v[F_INSTR_END] = status_rd;
        set_v[F_CS_UP]     = ev_cs_rise;
        clr_v[F_CS_UP]     = status_rd;
        set_v[F_TX_IDLE]   = tx_all_zero;
        clr_v[F_TX_IDLE]   = !tx_all_zero;
        set_v[F_RX_IDLE]   = rx_all_zero;
        clr_v[F_RX_IDLE]   = !rx_all_zero;
        set_v[F_TX_DONE]   = (tx_cnt == '0) && !tx_prev_zero_q;
        clr_v[F_TX_DONE]   = tx_cnt_wr;
        set_v[F_RX_DONE]   = (rx_cnt == '0) && !rx_prev_zero_q;
        clr_v[F_RX_DONE]   = rx_cnt_wr;
    end

    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
        qsts_flag #(.RESET_VAL(RESET_VALUE[FLAG_POS[k]])) u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (set_v[k]),
            .clr   (clr_v[k]),
            .q     (flag_q[k])
        );
    end

    // overrun flag kept separately; it sits below the counter flags
    qsts_flag #(.RESET_VAL(RESET_VALUE[B_OVERRUN])) u_ovr (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (ev_overrun),
        .clr   (status_rd),
        .q     (ovr_q)
    );

    always_comb begin
        status = '0;
        for (int k = 0; k < NUM_FLAGS; k++) status[FLAG_POS[k]] = flag_q[k];
        status[B_OVERRUN] = ovr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(status & irq_mask);
    end
    assign irq = irq_q;

    // R2: a read without the control command keeps the time-out flag
    assert_tout_kept_on_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status[17] && status_rd && !tout_clr) |=> status[17]);

    // R3: a detected rise reaches the status word at the next edge
    assert_line_rise_flagged_R3: assert property (@(posedge clk) disable iff (!rst_n)
        line_rise |=> status[13]);

    // R4: command start with no new rise clears bit 15
    assert_cmd_start_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_cmd_start && !ev_cs_rise) |=> !status[15]);

    // R6: read without a new instruction end clears bit 10
    assert_read_clears_instr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !ev_instr_end) |=> !status[10]);

    // R7: bit 11 cannot rise while no write accesses are configured
    assert_last_wr_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[11] && (wr_access_count == '0)) |=> !status[11]);

    // R10: an overrun that meets a read still leaves the flag set
    assert_set_beats_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_overrun && status_rd) |=> status[3]);
endmodule

// File: tb/tb_qsts_status_capture.sv
`timescale 1ns/1ps
module tb_qsts_status_capture;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_cs_rise = 0, ev_cs_fall = 0, ev_cmd_start = 0, ev_cmd_end = 0;
    logic ev_last_wr = 0, ev_instr_end = 0, ev_timeout = 0, ev_overrun = 0;
    logic [CNT_W-1:0] wr_access_count = 1;
    logic tout_clr = 0;
    logic [CNT_W-1:0] tx_cnt = 0, tx_next_cnt = 0, rx_cnt = 0, rx_next_cnt = 0;
    logic tx_cnt_wr = 0, rx_cnt_wr = 0, mem_irq_raw = 0, status_rd = 0;
    logic [31:0] irq_mask = 0;
    logic [31:0] status;
    logic irq;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    qsts_status_capture #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .ev_cs_rise(ev_cs_rise), .ev_cs_fall(ev_cs_fall),
        .ev_cmd_start(ev_cmd_start), .ev_cmd_end(ev_cmd_end),
        .ev_last_wr(ev_last_wr), .ev_instr_end(ev_instr_end),
        .ev_timeout(ev_timeout), .ev_overrun(ev_overrun),
        .wr_access_count(wr_access_count), .tout_clr(tout_clr),
        .tx_cnt(tx_cnt), .tx_next_cnt(tx_next_cnt),
        .rx_cnt(rx_cnt), .rx_next_cnt(rx_next_cnt),
        .tx_cnt_wr(tx_cnt_wr), .rx_cnt_wr(rx_cnt_wr),
        .mem_irq_raw(mem_irq_raw), .status_rd(status_rd),
        .irq_mask(irq_mask), .status(status), .irq(irq)
    );

    // {timeout, cs_rise, cs_fall, cmd_start, cmd_end, last_wr, instr_end, overrun}, rd, tout_clr, expected
    localparam int NV = 13;
    localparam logic [41:0] VEC [NV] = '{
        {8'b0100_0000, 1'b0, 1'b0, 32'h0000_81F0},  // R4 R6 cs rise sets 15 and 8
        {8'b0001_0000, 1'b0, 1'b0, 32'h0000_01F0},  // R4 cmd start clears 15
        {8'b0000_0000, 1'b1, 1'b0, 32'h0000_00F0},  // R6 read clears 8
        {8'b0010_0000, 1'b0, 1'b0, 32'h0000_40F0},  // R5 cs fall sets 14
        {8'b0000_1000, 1'b0, 1'b0, 32'h0000_00F0},  // R5 cmd end clears 14
        {8'b0000_0110, 1'b0, 1'b0, 32'h0000_0CF0},  // R6 last write and instr end
        {8'b0000_0001, 1'b1, 1'b0, 32'h0000_00F8},  // R6 R10 read clears 11/10, overrun wins
        {8'b1000_0000, 1'b0, 1'b0, 32'h0002_00F8},  // R2 time-out sets 17
        {8'b0000_0000, 1'b1, 1'b0, 32'h0002_00F0},  // R2 read keeps 17
        {8'b0000_0000, 1'b0, 1'b1, 32'h0000_00F0},  // R2 control command clears 17
        {8'b0010_1000, 1'b0, 1'b0, 32'h0000_40F0},  // R10 fall beats cmd end
        {8'b0100_0000, 1'b1, 1'b0, 32'h0000_81F0},  // R10 rise beats read
        {8'b0001_0000, 1'b1, 1'b0, 32'h0000_00F0}   // R4 R6 both clears
    };
    localparam int VEC_REQ [NV] = '{4, 4, 6, 5, 5, 6, 10, 2, 2, 2, 10, 10, 4};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_events(input logic [7:0] ev);
        {ev_timeout, ev_cs_rise, ev_cs_fall, ev_cmd_start,
         ev_cmd_end, ev_last_wr, ev_instr_end, ev_overrun} = ev;
    endtask

    initial begin
        #(5 * 150000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 status", status, 32'h0000_00F0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        step();
        check("R1 after release", status, 32'h0000_00F0);

        for (int i = 0; i < NV; i++) begin
            set_events(VEC[i][41:34]);
            status_rd = VEC[i][33];
            tout_clr  = VEC[i][32];
            step();
            set_events(8'h00);
            status_rd = 1'b0;
            tout_clr  = 1'b0;
            check($sformatf("R%0d vector %0d", VEC_REQ[i], i), status, VEC[i][31:0]);
        end

        // R11: everything set at once, undefined bits stay zero
        set_events(8'hFF);
        step();
        set_events(8'h00);
        check("R11 undefined bits", status & 32'hFFFD_0207, 32'h0);
        check("R11 full word", status, 32'h0002_CDF8);
        status_rd = 1'b1; tout_clr = 1'b1;
        step();
        status_rd = 1'b0; tout_clr = 1'b0;
        check("R11 cleared", status, 32'h0000_00F0);

        // R7: no configured write accesses
        wr_access_count = 0;
        ev_last_wr = 1'b1;
        step();
        ev_last_wr = 1'b0;
        check("R7 gated", status, 32'h0000_00F0);
        wr_access_count = 1;

        // R3: line rise, three edges of latency
        mem_irq_raw = 1'b1;
        step(); step();
        check("R3 rise too early", status, 32'h0000_00F0);
        step();
        check("R3 rise", status, 32'h0000_20F0);
        status_rd = 1'b1;
        step();
        status_rd = 1'b0;
        check("R3 rise read clear", status, 32'h0000_00F0);
        mem_irq_raw = 1'b0;
        step(); step();
        check("R3 fall too early", status, 32'h0000_00F0);
        step();
        check("R3 fall", status, 32'h0000_10F0);
        status_rd = 1'b1;
        step();
        status_rd = 1'b0;
        check("R3 fall read clear", status, 32'h0000_00F0);

        // R8 / R9 transmit side
        tx_cnt = 5;
        step();
        check("R8 tx busy", status, 32'h0000_0070);
        tx_cnt_wr = 1'b1;
        step();
        tx_cnt_wr = 1'b0;
        check("R9 tx write clears", status, 32'h0000_0050);
        tx_cnt = 0; tx_next_cnt = 3;
        step();
        check("R9 tx reach zero, R8 next busy", status, 32'h0000_0070);
        tx_next_cnt = 0;
        step();
        check("R8 tx idle", status, 32'h0000_00F0);
        tx_cnt_wr = 1'b1;
        step();
        tx_cnt_wr = 1'b0;
        check("R9 tx write at zero", status, 32'h0000_00D0);
        step();
        check("R9 tx no reset at zero", status, 32'h0000_00D0);

        // R8 / R9 receive side
        rx_next_cnt = 2;
        step();
        check("R8 rx busy", status, 32'h0000_0090);
        rx_next_cnt = 0;
        rx_cnt_wr = 1'b1;
        step();
        rx_cnt_wr = 1'b0;
        check("R8 rx idle R9 rx clear", status, 32'h0000_00C0);
        rx_cnt = 7;
        step();
        rx_cnt = 0;
        step();
        check("R9 rx reach zero", status, 32'h0000_00D0);

        // R12: masked interrupt, one cycle behind status
        irq_mask = 32'h0000_0008;
        ev_overrun = 1'b1;
        step();
        ev_overrun = 1'b0;
        check("R12 status bit", {31'b0, status[3]}, 32'h1);
        check("R12 irq lags", {31'b0, irq}, 32'h0);
        step();
        check("R12 irq raised", {31'b0, irq}, 32'h1);
        irq_mask = 32'h0;
        step();
        check("R12 irq masked", {31'b0, irq}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule